// File: doc/BRIEF.md
# GPIO register bank with keyed write lock

This block is the configuration store of a 32-pin general-purpose I/O controller. A simple word-wide bus reaches it, with valid, write flag, byte address, write data, registered read data and a registered error flag. It holds the direction, output data, polarity, output type, pull, input mask, slew, drive-strength and event configuration words. It also keeps the event status word: the event logic sets bits in it, and software clears them by writing ones. Each configuration word is presented on its own output port, so the neighbouring pin-resolution and event-detection logic reads the register contents directly.

Output data, output enable and event enable each have a pair of write-only alias words. A write to the set alias ORs the written mask into the target. A write to the clear alias removes the masked bits from the target. A global write lock protects the whole bank. Any write to either of the two lock words engages it. While it is engaged, every other write is dropped and flagged. The lock is released only when the second lock word holds the first key word and a write of the second key word then arrives at the first lock word. The pin-mux, debounce and blink words are storage-only. The two per-pin lock words accept writes and ignore them.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every register reads zero and the bank is unlocked, with four exceptions: pull-up, pull-down, slew and drive strength load their per-pin reset parameters.
- R2: Read/write words live at fixed byte offsets: polarity 0x08, output data 0x0C, output enable 0x10, output type 0x14, pin mux 0x18, pull-up 0x1C, pull-down 0x20, debounce 0x24, event type 0x28, both-edge 0x2C, blink 0x30–0x3C, event enable 0x40, event status 0x4C, input mask 0x58, slew 0x5C, drive 0x60. A write takes effect at the clock edge that samples it, and the matching output port shows the new value from then on. Read data appears in the cycle after the request.
- R3: Set aliases OR the written mask into their target, and clear aliases clear the masked bits of their target. The pairs are output data (0x68 set, 0x6C clear), output enable (0x70 set, 0x74 clear) and event enable (0x44 set, 0x48 clear).
- R4: The six alias words and lock word 2 (0x7C) are write-only and read as zero without an error.
- R5: Offset 0x04 reads the live input-data value from the pin logic. A write to it has no effect and raises the error flag.
- R6: While unlocked, a write of any value to lock word 1 (0x00) or lock word 2 (0x7C) engages the lock and clears lock word 2. Lock word 1 reads 1 when locked and 0 when unlocked.
- R7: While locked, a write to any offset other than the two lock words changes nothing and raises the error flag. Reads still work.
- R8: While locked, a write to lock word 2 stores its value. A write of 0xC0DEFA73 to lock word 1 unlocks the bank and zeroes lock word 2, but only if lock word 2 holds 0xC0DE1248. Any other lock word 1 write leaves the bank locked and lock word 2 unchanged.
- R9: Event status bits are set by the event-set input and cleared by writing ones to 0x4C. If a bit is set and cleared in the same cycle, the set wins.
- R10: Unaligned accesses (address bits [1:0] not zero), the unmapped offsets 0x64 and 0x78, and anything at or above 0x80 raise the error flag, read zero and change nothing. The per-pin lock words 0x50 and 0x54 accept writes without effect or error and read zero.
- R11: The error flag is high for exactly one cycle, in the cycle after an offending access, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Error pulse, one cycle after the request |
| din_i | input | NPIN | Input-data value from the pin logic |
| evt_set_i | input | NPIN | Event status set bits from the event logic |
| locked_o | output | 1 | Write lock engaged |
| pol_o | output | NPIN | Polarity register |
| dout_o | output | NPIN | Output data register |
| oe_o | output | NPIN | Output enable register |
| otype_o | output | NPIN | Output type (open-drain) register |
| pullup_o | output | NPIN | Pull-up register |
| pulldn_o | output | NPIN | Pull-down register |
| evtype_o | output | NPIN | Event type register |
| evboth_o | output | NPIN | Both-edge register |
| evten_o | output | NPIN | Event enable register |
| evst_o | output | NPIN | Event status register |
| inmask_o | output | NPIN | Input mask register |
| slew_o | output | NPIN | Slew register |
| drive_o | output | NPIN | Drive-strength register |

## Verification
The embedded properties check several rules on every cycle. The lock engages on any unlocked lock write, and it never releases without the exact key pair. A locked write to a configuration word leaves its outputs stable and pulses the error flag. Set and clear aliases always leave the masked bits in the right state, and write-only words read zero. Other behaviour shows only in the bench's scenarios: the absolute reset values, the offset map, the exact bit results of alias sequences, the set-over-clear priority of event status, and the difference between the two orders of key writes (only one of them unlocks).

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

  localparam int BUS_W = 32;

  localparam logic [31:0] KEY_FIRST  = 32'hC0DE1248;
  localparam logic [31:0] KEY_SECOND = 32'hC0DEFA73;

  typedef enum logic [2:0] {
    K_BAD,
    K_PLAIN,
    K_LOCK1,
    K_LOCK2,
    K_DIN,
    K_EVST,
    K_NULL
  } kind_e;

  typedef enum logic [1:0] {
    OP_WR,
    OP_SET,
    OP_CLR
  } op_e;

  localparam int F_POL   = 0;
  localparam int F_DOUT  = 1;
  localparam int F_OE    = 2;
  localparam int F_OTYP  = 3;
  localparam int F_MUX   = 4;
  localparam int F_PU    = 5;
  localparam int F_PD    = 6;
  localparam int F_DBNC  = 7;
  localparam int F_ETYP  = 8;
  localparam int F_EBOTH = 9;
  localparam int F_BLK0  = 10;
  localparam int F_BLK1  = 11;
  localparam int F_BLK2  = 12;
  localparam int F_BLK3  = 13;
  localparam int F_EEN   = 14;
  localparam int F_IMASK = 15;
  localparam int F_SLEW  = 16;
  localparam int F_DRV   = 17;
  localparam int NUM_F   = 18;
  localparam int FIDX_W  = $clog2(NUM_F);

  typedef struct packed {
    kind_e             kind;
    op_e               op;
    logic [FIDX_W-1:0] fidx;
    logic              wo;
  } dec_t;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              aligned,
  output dec_t              dec
);

  localparam int WORD_LSB = 2;
  localparam int WORD_MSB = 6;

  logic       above;
  logic [4:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign above   = |addr[ADDR_W-1:WORD_MSB+1];
  assign word    = addr[WORD_MSB:WORD_LSB];

  function automatic dec_t plain(input int f, input op_e o, input logic w);
    dec_t d;
    d.kind = K_PLAIN;
    d.op   = o;
    d.fidx = FIDX_W'(f);
    d.wo   = w;
    return d;
  endfunction

  function automatic dec_t other(input kind_e k);
    dec_t d;
    d.kind = k;
    d.op   = OP_WR;
    d.fidx = '0;
    d.wo   = 1'b0;
    return d;
  endfunction

  always_comb begin
    dec = other(K_BAD);
    if (!above) begin
      case (word)
        5'h00: dec = other(K_LOCK1);
        5'h01: dec = other(K_DIN);
        5'h02: dec = plain(F_POL,   OP_WR,  1'b0);
        5'h03: dec = plain(F_DOUT,  OP_WR,  1'b0);
        5'h04: dec = plain(F_OE,    OP_WR,  1'b0);
        5'h05: dec = plain(F_OTYP,  OP_WR,  1'b0);
        5'h06: dec = plain(F_MUX,   OP_WR,  1'b0);
        5'h07: dec = plain(F_PU,    OP_WR,  1'b0);
        5'h08: dec = plain(F_PD,    OP_WR,  1'b0);
        5'h09: dec = plain(F_DBNC,  OP_WR,  1'b0);
        5'h0A: dec = plain(F_ETYP,  OP_WR,  1'b0);
        5'h0B: dec = plain(F_EBOTH, OP_WR,  1'b0);
        5'h0C: dec = plain(F_BLK0,  OP_WR,  1'b0);
        5'h0D: dec = plain(F_BLK1,  OP_WR,  1'b0);
        5'h0E: dec = plain(F_BLK2,  OP_WR,  1'b0);
        5'h0F: dec = plain(F_BLK3,  OP_WR,  1'b0);
        5'h10: dec = plain(F_EEN,   OP_WR,  1'b0);
        5'h11: dec = plain(F_EEN,   OP_SET, 1'b1);
        5'h12: dec = plain(F_EEN,   OP_CLR, 1'b1);
        5'h13: dec = other(K_EVST);
        5'h14: dec = other(K_NULL);
        5'h15: dec = other(K_NULL);
        5'h16: dec = plain(F_IMASK, OP_WR,  1'b0);
        5'h17: dec = plain(F_SLEW,  OP_WR,  1'b0);
        5'h18: dec = plain(F_DRV,   OP_WR,  1'b0);
        5'h1A: dec = plain(F_DOUT,  OP_SET, 1'b1);
        5'h1B: dec = plain(F_DOUT,  OP_CLR, 1'b1);
        5'h1C: dec = plain(F_OE,    OP_SET, 1'b1);
        5'h1D: dec = plain(F_OE,    OP_CLR, 1'b1);
        5'h1F: dec = other(K_LOCK2);
        default: dec = other(K_BAD);
      endcase
    end
  end

endmodule

// File: rtl/gpio_rb_field.sv
module gpio_rb_field
  import gpio_rb_pkg::*;
#(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  op_e          op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (we) begin
      case (op)
        OP_SET:  q <= q | wdata;
        OP_CLR:  q <= q & ~wdata;
        default: q <= wdata;
      endcase
    end
  end

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_CLR) |=> ((q & $past(wdata)) == '0));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/gpio_rb_lock.sv
module gpio_rb_lock
  import gpio_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_l1,
  input  logic             wr_l2,
  input  logic [BUS_W-1:0] wdata,
  output logic             locked_o
);

  logic             locked_q;
  logic [BUS_W-1:0] key_q;
  logic             key_ok;

  assign key_ok   = wr_l1 && (wdata == KEY_SECOND) && (key_q == KEY_FIRST);
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      key_q    <= '0;
    end else if (!locked_q) begin
      if (wr_l1 || wr_l2) begin
        locked_q <= 1'b1;
        key_q    <= '0;
      end
    end else if (key_ok) begin
      locked_q <= 1'b0;
      key_q    <= '0;
    end else if (wr_l2) begin
      key_q <= wdata;
    end
  end

  assert_engage_R6: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && (wr_l1 || wr_l2)) |=> (locked_q && key_q == '0));

  assert_stay_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !(wr_l1 && wdata == KEY_SECOND && key_q == KEY_FIRST)) |=> locked_q);

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_l1 && wdata == KEY_SECOND && key_q == KEY_FIRST)
      |=> (!locked_q && key_q == '0));

  assert_key_store_R8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_l2) |=> (key_q == $past(wdata)));

endmodule

// File: rtl/gpio_rb_evstat.sv
module gpio_rb_evstat #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] st_o
);

  logic [W-1:0] keep;

  assign keep = clr_we ? ~clr_mask : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_o <= '0;
    end else begin
      st_o <= (st_o & keep) | set_bits;
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((st_o & $past(set_bits)) == $past(set_bits)));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (clr_mask & set_bits) == '0) |=> ((st_o & $past(clr_mask)) == '0));

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              NPIN       = 32,
  parameter logic [NPIN-1:0] RST_PULLUP = '0,
  parameter logic [NPIN-1:0] RST_PULLDN = '0,
  parameter logic [NPIN-1:0] RST_SLEW   = '0,
  parameter logic [NPIN-1:0] RST_DRIVE  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [NPIN-1:0]   din_i,
  input  logic [NPIN-1:0]   evt_set_i,
  output logic              locked_o,
  output logic [NPIN-1:0]   pol_o,
  output logic [NPIN-1:0]   dout_o,
  output logic [NPIN-1:0]   oe_o,
  output logic [NPIN-1:0]   otype_o,
  output logic [NPIN-1:0]   pullup_o,
  output logic [NPIN-1:0]   pulldn_o,
  output logic [NPIN-1:0]   evtype_o,
  output logic [NPIN-1:0]   evboth_o,
  output logic [NPIN-1:0]   evten_o,
  output logic [NPIN-1:0]   evst_o,
  output logic [NPIN-1:0]   inmask_o,
  output logic [NPIN-1:0]   slew_o,
  output logic [NPIN-1:0]   drive_o
);

  dec_t            dec;
  logic            aligned;
  logic            acc_ok;
  logic            wr;
  logic            rd;
  logic            wr_open;
  logic            locked;
  logic [NUM_F-1:0] fld_we;
  logic [NPIN-1:0] fq [NUM_F];
  logic [NPIN-1:0] sel_q;
  logic [31:0]     rd_next;
  logic            err_next;

  gpio_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .aligned (aligned),
    .dec     (dec)
  );

  assign acc_ok  = bus_valid && aligned;
  assign wr      = acc_ok && bus_write;
  assign rd      = acc_ok && !bus_write;
  assign wr_open = wr && !locked;

  gpio_rb_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_l1    (wr && dec.kind == K_LOCK1),
    .wr_l2    (wr && dec.kind == K_LOCK2),
    .wdata    (bus_wdata),
    .locked_o (locked)
  );

  always_comb begin
    for (int i = 0; i < NUM_F; i++) begin
      fld_we[i] = wr_open && dec.kind == K_PLAIN && dec.fidx == FIDX_W'(i);
    end
  end

  for (genvar i = 0; i < NUM_F; i++) begin : g_fld
    localparam logic [NPIN-1:0] RV = (i == F_PU)   ? RST_PULLUP :
                                     (i == F_PD)   ? RST_PULLDN :
                                     (i == F_SLEW) ? RST_SLEW   :
                                     (i == F_DRV)  ? RST_DRIVE  : '0;
    gpio_rb_field #(.W(NPIN), .RST_VAL(RV)) u_f (
      .clk   (clk),
      .rst   (rst),
      .we    (fld_we[i]),
      .op    (dec.op),
      .wdata (bus_wdata[NPIN-1:0]),
      .q     (fq[i])
    );
  end

  gpio_rb_evstat #(.W(NPIN)) u_evst (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (wr_open && dec.kind == K_EVST),
    .clr_mask (bus_wdata[NPIN-1:0]),
    .set_bits (evt_set_i),
    .st_o     (evst_o)
  );

  always_comb begin
    sel_q = '0;
    for (int i = 0; i < NUM_F; i++) begin
      if (dec.fidx == FIDX_W'(i)) sel_q = fq[i];
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd) begin
      case (dec.kind)
        K_PLAIN: rd_next = dec.wo ? 32'h0 : 32'(sel_q);
        K_LOCK1: rd_next = 32'(locked);
        K_DIN:   rd_next = 32'(din_i);
        K_EVST:  rd_next = 32'(evst_o);
        default: rd_next = '0;
      endcase
    end
  end

  always_comb begin
    err_next = 1'b0;
    if (bus_valid) begin
      if (!aligned || dec.kind == K_BAD) begin
        err_next = 1'b1;
      end else if (bus_write) begin
        if (dec.kind == K_DIN) begin
          err_next = 1'b1;
        end else if (locked && dec.kind != K_LOCK1 && dec.kind != K_LOCK2) begin
          err_next = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      bus_err   <= err_next;
    end
  end

  assign locked_o = locked;
  assign pol_o    = fq[F_POL];
  assign dout_o   = fq[F_DOUT];
  assign oe_o     = fq[F_OE];
  assign otype_o  = fq[F_OTYP];
  assign pullup_o = fq[F_PU];
  assign pulldn_o = fq[F_PD];
  assign evtype_o = fq[F_ETYP];
  assign evboth_o = fq[F_EBOTH];
  assign evten_o  = fq[F_EEN];
  assign inmask_o = fq[F_IMASK];
  assign slew_o   = fq[F_SLEW];
  assign drive_o  = fq[F_DRV];

  assert_locked_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && locked && dec.kind == K_PLAIN)
      |=> ($stable(dout_o) && $stable(oe_o) && $stable(pol_o) && $stable(evten_o) && bus_err));

  assert_wo_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd && (dec.kind == K_LOCK2 || (dec.kind == K_PLAIN && dec.wo))) |=> (bus_rdata == 32'h0));

  assert_din_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && dec.kind == K_DIN) |=> bus_err);

  assert_err_origin_R11: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid));

  assert_bad_access_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (!aligned || dec.kind == K_BAD)) |=> (bus_err && bus_rdata == 32'h0));

endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;

  localparam int          CLK_P  = 10;
  localparam int          ADDR_W = 12;
  localparam logic [31:0] RPU    = 32'h0000_00F0;
  localparam logic [31:0] RPD    = 32'h0F00_0000;
  localparam logic [31:0] RSL    = 32'h0000_0003;
  localparam logic [31:0] RDR    = 32'h8000_0000;
  localparam logic [31:0] K1     = 32'hC0DE1248;
  localparam logic [31:0] K2     = 32'hC0DEFA73;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_err;
  logic [31:0]       din_i = '0;
  logic [31:0]       evt_set_i = '0;
  logic              locked_o;
  logic [31:0]       pol_o, dout_o, oe_o, otype_o, pullup_o, pulldn_o;
  logic [31:0]       evtype_o, evboth_o, evten_o, evst_o, inmask_o, slew_o, drive_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] q_rd  [$];
  logic        q_chk [$];
  logic        q_err [$];
  string       q_tag [$];

  always #(CLK_P/2) clk = ~clk;

  gpio_regbank #(
    .ADDR_W(ADDR_W), .NPIN(32),
    .RST_PULLUP(RPU), .RST_PULLDN(RPD), .RST_SLEW(RSL), .RST_DRIVE(RDR)
  ) u_dut (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .din_i(din_i), .evt_set_i(evt_set_i), .locked_o(locked_o),
    .pol_o(pol_o), .dout_o(dout_o), .oe_o(oe_o), .otype_o(otype_o),
    .pullup_o(pullup_o), .pulldn_o(pulldn_o), .evtype_o(evtype_o),
    .evboth_o(evboth_o), .evten_o(evten_o), .evst_o(evst_o),
    .inmask_o(inmask_o), .slew_o(slew_o), .drive_o(drive_o)
  );

  // Monitor: pops one expected item per bus access and compares it
  initial begin
    forever begin
      @(posedge clk);
      if (bus_valid === 1'b1 && rst === 1'b0) begin
        logic [31:0] erd;
        logic        echk;
        logic        eerr;
        string       etag;
        @(negedge clk);
        erd  = q_rd.pop_front();
        echk = q_chk.pop_front();
        eerr = q_err.pop_front();
        etag = q_tag.pop_front();
        n_vec++;
        if ((echk && bus_rdata !== erd) || bus_err !== eerr) begin
          n_bad++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                   etag, bus_rdata, bus_err, erd, eerr);
        end
      end
    end
  end

  task automatic bus(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input logic chk_rd, input logic [31:0] exp_rd,
                     input logic exp_err, input string tag);
    q_rd.push_back(exp_rd);
    q_chk.push_back(chk_rd);
    q_err.push_back(exp_err);
    q_tag.push_back(tag);
    bus_valid = 1'b1;
    bus_write = w;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                    input logic exp_err, input string tag);
    bus(1'b1, a, d, 1'b0, 32'h0, exp_err, tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp_rd,
                    input logic exp_err, input string tag);
    bus(1'b0, a, 32'h0, 1'b1, exp_rd, exp_err, tag);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 pullup reset", pullup_o, RPU);
    chk("R1 pulldown reset", pulldn_o, RPD);
    chk("R1 slew reset", slew_o, RSL);
    chk("R1 drive reset", drive_o, RDR);
    chk("R1 dout reset", dout_o, 32'h0);
    chk("R1 oe reset", oe_o, 32'h0);
    chk("R1 locked reset", {31'b0, locked_o}, 32'h0);
    chk("R1 evst reset", evst_o, 32'h0);
    rd(12'h000, 32'h0, 1'b0, "R1 lock1 reads 0");
    rd(12'h01C, RPU, 1'b0, "R1 pullup readback");

    // R2 plain registers
    wr(12'h008, 32'hA5A5_0001, 1'b0, "R2 write polarity");
    chk("R2 pol_o", pol_o, 32'hA5A5_0001);
    rd(12'h008, 32'hA5A5_0001, 1'b0, "R2 read polarity");
    wr(12'h00C, 32'h1234_5678, 1'b0, "R2 write dout");
    chk("R2 dout_o", dout_o, 32'h1234_5678);
    wr(12'h058, 32'hFFFF_0000, 1'b0, "R2 write inmask");
    chk("R2 inmask_o", inmask_o, 32'hFFFF_0000);
    wr(12'h028, 32'h0000_00C3, 1'b0, "R2 write evtype");
    wr(12'h02C, 32'h0000_0081, 1'b0, "R2 write both-edge");
    chk("R2 evtype_o", evtype_o, 32'h0000_00C3);
    chk("R2 evboth_o", evboth_o, 32'h0000_0081);
    wr(12'h034, 32'h0000_0055, 1'b0, "R2 write blink1");
    rd(12'h034, 32'h0000_0055, 1'b0, "R2 read blink1");
    wr(12'h014, 32'h0000_F000, 1'b0, "R2 write otype");
    chk("R2 otype_o", otype_o, 32'h0000_F000);

    // R3 set / clear aliases
    wr(12'h068, 32'h0000_FF00, 1'b0, "R3 dout set");
    chk("R3 dout after set", dout_o, 32'h1234_FF78);
    wr(12'h06C, 32'h0000_0078, 1'b0, "R3 dout clear");
    chk("R3 dout after clear", dout_o, 32'h1234_FF00);
    wr(12'h070, 32'h0000_000F, 1'b0, "R3 oe set");
    wr(12'h074, 32'h0000_0005, 1'b0, "R3 oe clear");
    chk("R3 oe after set/clear", oe_o, 32'h0000_000A);
    wr(12'h044, 32'h0000_0030, 1'b0, "R3 een set a");
    wr(12'h044, 32'h0000_0003, 1'b0, "R3 een set b");
    wr(12'h048, 32'h0000_0010, 1'b0, "R3 een clear");
    chk("R3 evten after set/clear", evten_o, 32'h0000_0023);

    // R4 write-only words read zero
    rd(12'h068, 32'h0, 1'b0, "R4 dout-set reads 0");
    rd(12'h044, 32'h0, 1'b0, "R4 een-set reads 0");
    rd(12'h074, 32'h0, 1'b0, "R4 oe-clear reads 0");
    rd(12'h07C, 32'h0, 1'b0, "R4 lock2 reads 0");
    rd(12'h040, 32'h0000_0023, 1'b0, "R4 een target reads value");

    // R5 input data
    din_i = 32'hDEAD_BEEF;
    rd(12'h004, 32'hDEAD_BEEF, 1'b0, "R5 read din");
    wr(12'h004, 32'h0000_0001, 1'b1, "R5 write din flagged");
    rd(12'h004, 32'hDEAD_BEEF, 1'b0, "R5 din unchanged");

    // R9 event status
    evt_set_i = 32'h0000_000F;
    idle(1);
    evt_set_i = 32'h0;
    chk("R9 evst after set", evst_o, 32'h0000_000F);
    wr(12'h04C, 32'h0000_0005, 1'b0, "R9 evst w1c");
    chk("R9 evst after w1c", evst_o, 32'h0000_000A);
    rd(12'h04C, 32'h0000_000A, 1'b0, "R9 read evst");
    evt_set_i = 32'h0000_0002;
    wr(12'h04C, 32'h0000_0002, 1'b0, "R9 set and clear same cycle");
    evt_set_i = 32'h0;
    chk("R9 set wins", evst_o, 32'h0000_000A);
    wr(12'h04C, 32'hFFFF_FFFF, 1'b0, "R9 clear all");
    chk("R9 evst cleared", evst_o, 32'h0);

    // R10 bad accesses
    rd(12'h064, 32'h0, 1'b1, "R10 read unmapped 0x64");
    wr(12'h078, 32'hFFFF_FFFF, 1'b1, "R10 write unmapped 0x78");
    wr(12'h00A, 32'hFFFF_FFFF, 1'b1, "R10 unaligned write");
    chk("R10 pol unchanged", pol_o, 32'hA5A5_0001);
    rd(12'h009, 32'h0, 1'b1, "R10 unaligned read");
    rd(12'h100, 32'h0, 1'b1, "R10 read above window");
    wr(12'h050, 32'hFFFF_FFFF, 1'b0, "R10 pin-lock write ignored");
    rd(12'h050, 32'h0, 1'b0, "R10 pin-lock reads 0");

    // R11 error is a single pulse
    wr(12'h064, 32'h0, 1'b1, "R11 error pulse");
    idle(1);
    chk("R11 error gone after one cycle", {31'b0, bus_err}, 32'h0);

    // R6 engage lock via lock2
    wr(12'h07C, 32'h0000_0005, 1'b0, "R6 lock2 write engages");
    chk("R6 locked_o", {31'b0, locked_o}, 32'h1);
    rd(12'h000, 32'h1, 1'b0, "R6 lock1 reads 1");
    rd(12'h07C, 32'h0, 1'b0, "R6 lock2 reads 0");

    // R7 locked writes dropped
    wr(12'h00C, 32'hFFFF_FFFF, 1'b1, "R7 locked dout write");
    chk("R7 dout unchanged", dout_o, 32'h1234_FF00);
    wr(12'h070, 32'h0000_FFFF, 1'b1, "R7 locked oe-set write");
    chk("R7 oe unchanged", oe_o, 32'h0000_000A);
    evt_set_i = 32'h0000_0001;
    idle(1);
    evt_set_i = 32'h0;
    wr(12'h04C, 32'h0000_0001, 1'b1, "R7 locked evst clear");
    chk("R7 evst kept", evst_o, 32'h0000_0001);
    rd(12'h008, 32'hA5A5_0001, 1'b0, "R7 read while locked");

    // R8 unlock rules
    wr(12'h000, K2, 1'b0, "R8 lock1 key without lock2 key");
    chk("R8 still locked a", {31'b0, locked_o}, 32'h1);
    wr(12'h07C, K1, 1'b0, "R8 store lock2 key");
    wr(12'h000, 32'h1234_5678, 1'b0, "R8 wrong lock1 value");
    chk("R8 still locked b", {31'b0, locked_o}, 32'h1);
    wr(12'h000, K2, 1'b0, "R8 correct lock1 key");
    chk("R8 unlocked", {31'b0, locked_o}, 32'h0);
    rd(12'h000, 32'h0, 1'b0, "R8 lock1 reads 0");
    wr(12'h000, 32'h0, 1'b0, "R6 lock1 write engages");
    chk("R6 locked via lock1", {31'b0, locked_o}, 32'h1);
    wr(12'h000, K2, 1'b0, "R8 reversed order first");
    wr(12'h07C, K1, 1'b0, "R8 reversed order second");
    chk("R8 reversed order stays locked", {31'b0, locked_o}, 32'h1);
    wr(12'h000, K2, 1'b0, "R8 key completes");
    chk("R8 unlocked again", {31'b0, locked_o}, 32'h0);
    wr(12'h00C, 32'h0000_0001, 1'b0, "R8 write after unlock");
    chk("R8 dout writable", dout_o, 32'h0000_0001);

    idle(2);
    finish_run();
  end

endmodule